// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting channel of a programmable interval timer. A host reaches it over an 8-bit bus through two write strobes and one read strobe. The control strobe takes a control byte. The data strobe loads the count one byte at a time, low byte first and high byte second. The read strobe steps through the count in the same low-then-high order. The count can be read live, or it can be frozen by a latch command so that both bytes come from the same instant.

The counter decrements once for every cycle in which `tick_i` is high, and stops when it reaches zero. In practice `tick_i` is a one-cycle enable derived from a nominal 1.19318 MHz timebase. The output bit is used as an interrupt request. It goes low whenever a new count is started. In interrupt-on-terminal-count mode it goes high when the count runs out.

A control byte that asks for something this channel does not support is rejected and raised on `err_o`. The unsupported requests are the read-back select, a one-byte access mode, a mode other than 0, 2 or 3, and BCD counting.

Top module: `timer_chan`

## Requirements
- R1: After reset the count is 0, `out_o` and `err_o` are low, `rdata_o` is 0, and both the read order and the write order point to the low byte.
- R2: Control bits 7:6 select the channel. A byte whose select equals `CHAN_ID` is decoded. Select 3 (read-back) sets `err_o`. Any other select leaves `err_o` and the channel configuration unchanged.
- R3: Control bits 5:4 give the access mode. 00 is a latch command and 11 is low-then-high access; both clear `err_o`. The values 01 and 10 set `err_o` and leave the configuration unchanged.
- R4: Control bits 3:1 give the operating mode and bit 0 selects BCD. Only modes 000, 010 and 011 with bit 0 clear are accepted. Any other combination sets `err_o` and keeps the previous mode.
- R5: A data write while the write order is low replaces count bits 7:0. It stops any countdown, drives `out_o` low on the next cycle, and moves the write order to the high byte.
- R6: A data write while the write order is high replaces count bits 15:8 and returns the write order to low. Counting starts only if the resulting 16-bit value is nonzero.
- R7: While running, the count drops by exactly one on each cycle with `tick_i` high. It never decrements below zero and stays at zero until reloaded.
- R8: In mode 0 `out_o` goes high on the same edge at which the count reaches zero. In modes 2 and 3 the expiry leaves `out_o` low.
- R9: `rdata_o` shows the low byte when the read order is low and the high byte when it is high. Each read strobe flips the order.
- R10: A latch command freezes the current count and sets the read order to low. Reads return the frozen value while counting continues. Reading the high byte releases the latch, and later reads show the live count.
- R11: A latch command issued while a frozen value is still unread is ignored. It changes neither the frozen value nor the read order.
- R12: A latch command in the same cycle as a tick freezes the value before the decrement. A low-byte write in the same cycle as a tick takes precedence over the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one decrement per high cycle |
| ctrl_we_i | input | 1 | Control byte write strobe |
| data_we_i | input | 1 | Count byte write strobe |
| data_re_i | input | 1 | Count byte read strobe |
| wdata_i | input | 8 | Write data shared by both write strobes |
| rdata_o | output | 8 | Currently selected count byte |
| out_o | output | 1 | Channel output bit |
| err_o | output | 1 | Verdict on the last control byte decoded by this channel |

## Verification
The counting path and the host path can act in the same cycle. The bench provokes this by asserting a latch command together with `tick_i`. It then reads the frozen bytes, which must carry the value from before the decrement, followed by the live count, which must be one lower. It also asserts a low-byte write together with `tick_i`. The written byte must appear unchanged on a later read, and further ticks must not move it, which shows that the write won and the countdown stopped.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam logic [1:0] SEL_RDBK  = 2'b11;
  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_LOHI  = 2'b11;
  localparam logic [2:0] MODE_TC   = 3'd0;
  localparam logic [2:0] MODE_RATE = 3'd2;
  localparam logic [2:0] MODE_SQW  = 3'd3;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_t;

  function automatic logic mode_ok(input logic [2:0] m);
    return (m == MODE_TC) || (m == MODE_RATE) || (m == MODE_SQW);
  endfunction
endpackage

// File: rtl/timer_ctrl_dec.sv
module timer_ctrl_dec
  import timer_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic       we_i,
  input  ctrl_t      byte_i,
  output logic       latch_o,
  output logic       cfg_o,
  output logic       bad_o,
  output logic [2:0] mode_o
);
  localparam logic [1:0] ID = CHAN_ID[1:0];

  logic hit, rdbk, good;

  assign hit  = we_i && (byte_i.sel == ID);
  assign rdbk = we_i && (byte_i.sel == SEL_RDBK);
  assign good = (byte_i.acc == ACC_LOHI) && mode_ok(byte_i.mode) && !byte_i.bcd;

  assign latch_o = hit && (byte_i.acc == ACC_LATCH);
  assign cfg_o   = hit && good;
  assign bad_o   = rdbk || (hit && (byte_i.acc != ACC_LATCH) && !good);
  assign mode_o  = byte_i.mode;
endmodule

// File: rtl/timer_cnt_core.sv
module timer_cnt_core #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              tick_i,
  input  logic              tc_mode_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              out_o
);
  logic wr_hi_q, run_q;
  logic [CNT_W-1:0] next_full;

  assign next_full = {data_i, count_o[BYTE_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      wr_hi_q <= 1'b0;
      run_q   <= 1'b0;
      out_o   <= 1'b0;
    end else if (we_i) begin
      if (!wr_hi_q) begin
        count_o[BYTE_W-1:0] <= data_i;
        run_q   <= 1'b0;
        out_o   <= 1'b0;
        wr_hi_q <= 1'b1;
      end else begin
        count_o[CNT_W-1:BYTE_W] <= data_i;
        run_q   <= (next_full != '0);
        wr_hi_q <= 1'b0;
      end
    end else if (run_q && tick_i) begin
      count_o <= count_o - 1'b1;
      if (count_o == CNT_W'(1)) begin
        run_q <= 1'b0;
        if (tc_mode_i) out_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/timer_rd_seq.sv
module timer_rd_seq #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic              re_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic             rd_hi_q, latched_q;
  logic [CNT_W-1:0] hold_q, src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
      hold_q    <= '0;
    end else if (latch_i && !latched_q) begin
      latched_q <= 1'b1;
      hold_q    <= count_i;
      rd_hi_q   <= 1'b0;
    end else if (re_i) begin
      rd_hi_q <= !rd_hi_q;
      if (rd_hi_q) latched_q <= 1'b0;
    end
  end

  assign src     = latched_q ? hold_q : count_i;
  assign rdata_o = rd_hi_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import timer_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int CHAN_ID = 0,
  localparam int CNT_W  = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ctrl_we_i,
  input  logic              data_we_i,
  input  logic              data_re_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              out_o,
  output logic              err_o
);
  logic             latch_cmd, cfg_ok, cfg_bad;
  logic [2:0]       new_mode, mode_q;
  logic [CNT_W-1:0] count_q;

  timer_ctrl_dec #(.CHAN_ID(CHAN_ID)) u_dec (
    .we_i    (ctrl_we_i),
    .byte_i  (ctrl_t'(wdata_i[7:0])),
    .latch_o (latch_cmd),
    .cfg_o   (cfg_ok),
    .bad_o   (cfg_bad),
    .mode_o  (new_mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_TC;
      err_o  <= 1'b0;
    end else begin
      if (cfg_ok) mode_q <= new_mode;
      if (cfg_ok || latch_cmd) err_o <= 1'b0;
      else if (cfg_bad)        err_o <= 1'b1;
    end
  end

  timer_cnt_core #(.BYTE_W(BYTE_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (data_we_i),
    .data_i    (wdata_i),
    .tick_i    (tick_i),
    .tc_mode_i (mode_q == MODE_TC),
    .count_o   (count_q),
    .out_o     (out_o)
  );

  timer_rd_seq #(.BYTE_W(BYTE_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .latch_i (latch_cmd),
    .re_i    (data_re_i),
    .count_i (count_q),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/timer_chan_chk.sv
module timer_chan_chk
  import timer_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int CHAN_ID = 0,
  localparam int CNT_W  = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic              data_we_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic              out_o,
  input logic              err_o,
  input logic [CNT_W-1:0]  count,
  input logic [2:0]        mode
);
  logic [1:0] sel;
  logic       own, good;
  assign sel  = wdata_i[7:6];
  assign own  = ctrl_we_i && (sel == CHAN_ID[1:0]);
  assign good = (wdata_i[5:4] == ACC_LOHI) && !wdata_i[0] &&
                (wdata_i[3:1] == MODE_TC || wdata_i[3:1] == MODE_RATE ||
                 wdata_i[3:1] == MODE_SQW);

  p_rdbk_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && sel == SEL_RDBK |=> err_o);
  p_other_chan_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && sel != CHAN_ID[1:0] && sel != SEL_RDBK |=> $stable(err_o));
  p_lohi_ok_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own && good |=> !err_o);
  p_bcd_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own && wdata_i[0] && wdata_i[5:4] != ACC_LATCH |=> err_o);
  p_no_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_we_i |=> count <= $past(count));
  p_zero_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count == '0 && !data_we_i |=> count == '0);
  p_out_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_o) |-> count == '0 && $past(mode) == MODE_TC);
endmodule

bind timer_chan timer_chan_chk #(.BYTE_W(BYTE_W), .CHAN_ID(CHAN_ID)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_we_i (ctrl_we_i),
  .data_we_i (data_we_i),
  .wdata_i   (wdata_i),
  .out_o     (out_o),
  .err_o     (err_o),
  .count     (count_q),
  .mode      (mode_q)
);

// File: tb/sim_timer_chan.sv
`timescale 1ns/1ps
module sim_timer_chan;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       tick = 1'b0, ctrl_we = 1'b0, data_we = 1'b0, data_re = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       out, err;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  timer_chan u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .ctrl_we_i(ctrl_we),
    .data_we_i(data_we), .data_re_i(data_re), .wdata_i(wdata),
    .rdata_o(rdata), .out_o(out), .err_o(err)
  );

  // {op, arg, expected, req}; op 0 ctrl, 1 data write, 2 read+check, 3 ticks
  localparam int NV = 19;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 8'h30, 8'h00, 4'd3},   // R3 mode 0, lo/hi
    {2'd1, 8'h05, 8'h00, 4'd5},   // R5
    {2'd1, 8'h00, 8'h00, 4'd6},   // R6
    {2'd2, 8'h00, 8'h05, 4'd9},   // R9
    {2'd2, 8'h00, 8'h00, 4'd9},
    {2'd3, 8'h02, 8'h00, 4'd7},   // R7
    {2'd2, 8'h00, 8'h03, 4'd7},
    {2'd2, 8'h00, 8'h00, 4'd7},
    {2'd0, 8'h00, 8'h00, 4'd10},  // R10 latch at 3
    {2'd3, 8'h01, 8'h00, 4'd10},
    {2'd0, 8'h00, 8'h00, 4'd11},  // R11 repeat latch at 2
    {2'd3, 8'h01, 8'h00, 4'd11},
    {2'd2, 8'h00, 8'h03, 4'd11},
    {2'd2, 8'h00, 8'h00, 4'd10},
    {2'd2, 8'h00, 8'h01, 4'd10},  // live again
    {2'd2, 8'h00, 8'h00, 4'd10},
    {2'd3, 8'h05, 8'h00, 4'd7},
    {2'd2, 8'h00, 8'h00, 4'd7},
    {2'd2, 8'h00, 8'h00, 4'd7}
  };

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_ctrl(input logic [7:0] b);
    @(negedge clk); ctrl_we = 1'b1; wdata = b;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] b);
    @(negedge clk); data_we = 1'b1; wdata = b;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic do_rd(input int req, input logic [7:0] exp);
    @(negedge clk); chk(req, rdata, exp); data_re = 1'b1;
    @(negedge clk); data_re = 1'b0;
  endtask

  task automatic do_tick(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, rdata, 8'h00); chk(1, {7'd0, out}, 8'h00); chk(1, {7'd0, err}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(1, rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][21:20])
        2'd0: do_ctrl(VEC[i][19:12]);
        2'd1: do_wr(VEC[i][19:12]);
        2'd2: do_rd(int'(VEC[i][3:0]), VEC[i][11:4]);
        default: do_tick(int'(VEC[i][19:12]));
      endcase
    end

    // R8 mode 0 expiry
    do_wr(8'h03); do_wr(8'h00);
    do_tick(2); chk(8, {7'd0, out}, 8'h00);
    do_tick(1); chk(8, {7'd0, out}, 8'h01);
    // R5 low write stops count and drops output
    do_wr(8'h07); chk(5, {7'd0, out}, 8'h00);
    do_tick(4); do_rd(5, 8'h07); do_rd(5, 8'h00);
    // R6 / R7 high write restarts
    do_wr(8'h01); do_tick(2); do_rd(6, 8'h05); do_rd(7, 8'h01);
    // R6 zero load never counts
    do_wr(8'h00); do_wr(8'h00); do_tick(3);
    do_rd(6, 8'h00); do_rd(6, 8'h00); chk(6, {7'd0, out}, 8'h00);
    // R8 modes 2 and 3 keep output low
    do_ctrl(8'h34); do_wr(8'h02); do_wr(8'h00); do_tick(3);
    chk(8, {7'd0, out}, 8'h00); do_rd(8, 8'h00);
    do_ctrl(8'h36); do_wr(8'h02); do_wr(8'h00); do_tick(3);
    chk(8, {7'd0, out}, 8'h00); do_rd(8, 8'h00);
    // R3 access modes
    do_ctrl(8'h10); chk(3, {7'd0, err}, 8'h01);
    do_ctrl(8'h34); chk(3, {7'd0, err}, 8'h00);
    do_ctrl(8'h20); chk(3, {7'd0, err}, 8'h01);
    // R4 bad mode or BCD rejected, mode 2 kept
    do_ctrl(8'h34);
    do_ctrl(8'h31); chk(4, {7'd0, err}, 8'h01);
    do_wr(8'h02); do_wr(8'h00); do_tick(2); chk(4, {7'd0, out}, 8'h00);
    do_ctrl(8'h3A); chk(4, {7'd0, err}, 8'h01);
    do_ctrl(8'h3C); chk(4, {7'd0, err}, 8'h01);
    // R2 select field
    do_ctrl(8'hC0); chk(2, {7'd0, err}, 8'h01);
    do_ctrl(8'h34); chk(2, {7'd0, err}, 8'h00);
    do_ctrl(8'h70); chk(2, {7'd0, err}, 8'h00);
    do_ctrl(8'h50); chk(2, {7'd0, err}, 8'h00);
    do_wr(8'h01); do_wr(8'h00); do_tick(1); chk(2, {7'd0, out}, 8'h00);
    // R12 latch and tick together
    do_ctrl(8'h30); do_wr(8'h10); do_wr(8'h00);
    @(negedge clk); ctrl_we = 1'b1; wdata = 8'h00; tick = 1'b1;
    @(negedge clk); ctrl_we = 1'b0; tick = 1'b0;
    do_rd(12, 8'h10); do_rd(12, 8'h00); do_rd(12, 8'h0F); do_rd(12, 8'h00);
    // R12 low write and tick together
    @(negedge clk); data_we = 1'b1; wdata = 8'h20; tick = 1'b1;
    @(negedge clk); data_we = 1'b0; tick = 1'b0;
    do_tick(3); do_rd(12, 8'h20); do_rd(12, 8'h00);
    do_wr(8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule